// File: doc/BRIEF.md
# Dual Byte FIFO with Trigger Levels

This block is the buffering stage of a serial port. It holds two independent byte queues. The transmit queue is filled from the processor side and drained by the serial engine. The receive queue is filled by the serial engine and drained by the processor. Each queue holds up to eight bytes. Both queues are managed through one 32-bit control/status word. That word shows the live occupancy of each queue and holds a two-bit trigger-level code for each direction. It also carries a write-one flush command for each queue that clears itself.

Two level outputs tell the surrounding logic when to act. The receive trigger is high while the receive queue holds at least its selected number of bytes. The transmit trigger is high while the transmit queue has drained to its selected level or below. A push into a full queue is dropped and sets a sticky overflow flag for that queue. A pop from an empty queue has no effect on the queue.

Top module: `uart_fifo_pair`

## Requirements
- R1: Each queue's occupancy counts from 0 to 8 and never goes above 8. The register word shows the receive count in bits [27:24] and the transmit count in bits [19:16].
- R2: The receive level code is written and read at bits [7:6]. The codes 00, 01, 10 and 11 select 1, 2, 4 and 6 bytes. `rx_trig_o` is high exactly while the receive count is at or above the selected level.
- R3: The transmit level code is written and read at bits [5:4]. The codes 00, 01, 10 and 11 select 0, 2, 4 and 6 bytes. `tx_trig_o` is high exactly while the transmit count is at or below the selected level.
- R4: A register write with bit 1 set empties the receive queue at that write's clock edge. Bit 1 always reads 0.
- R5: A register write with bit 0 set empties the transmit queue at that write's clock edge. Bit 0 always reads 0.
- R6: After reset the register reads 0x00000000, `rx_trig_o` is 0, `tx_trig_o` is 1, both overflow flags are 0 and both data outputs are 0.
- R7: Bytes leave each queue in the order they entered. A popped byte appears on the data output in the cycle after the pop and stays there until the next accepted pop.
- R8: A push into a full queue is dropped, even if a pop happens in the same cycle. It sets that queue's overflow flag, which stays set until reset.
- R9: A pop from an empty queue leaves the count at 0 and the data output unchanged.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged. On an empty queue the push is taken and the pop is ignored.
- R11: A flush in the same cycle as a push or pop wins. The queue ends up empty, the data output does not change, and no overflow is recorded.
- R12: Bits [31:28], [23:20] and [15:8] of the register, together with bits [3:2], read 0 and ignore writes. The level codes change only on a cycle with `reg_wr_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (counts and level codes) |
| tx_push_i | input | 1 | Processor pushes a byte into the transmit queue |
| tx_din_i | input | 8 | Byte to push into the transmit queue |
| tx_pop_i | input | 1 | Serial engine pops the transmit queue |
| tx_dout_o | output | 8 | Last byte popped from the transmit queue |
| tx_ovf_o | output | 1 | Sticky transmit overflow flag |
| tx_trig_o | output | 1 | Transmit queue at or below its level |
| rx_push_i | input | 1 | Serial engine pushes a received byte |
| rx_din_i | input | 8 | Byte to push into the receive queue |
| rx_pop_i | input | 1 | Processor pops the receive queue |
| rx_dout_o | output | 8 | Last byte popped from the receive queue |
| rx_ovf_o | output | 1 | Sticky receive overflow flag |
| rx_trig_o | output | 1 | Receive queue at or above its level |

## Verification
Each receive level code is tried by filling the queue one byte at a time and then draining it. This shows the exact count at which the trigger turns on, and so tells a wrong code mapping apart from an off-by-one compare. The transmit queue is pushed past full and popped past empty under each transmit code. That separates a dropped push from a wrapped pointer, and a stale data output from a bad pop. Directed cycles then combine push, pop and flush on empty, partly filled and full queues, to find out which operation wins. A long random mix with occasional register writes, random reserved bits included, finishes the check against a queue-based reference model.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned FIFO_DEPTH = 8;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FIELD_W    = 4;

  localparam int unsigned RX_CNT_LSB   = 24;
  localparam int unsigned TX_CNT_LSB   = 16;
  localparam int unsigned RX_CODE_LSB  = 6;
  localparam int unsigned TX_CODE_LSB  = 4;
  localparam int unsigned RX_FLUSH_BIT = 1;
  localparam int unsigned TX_FLUSH_BIT = 0;

  typedef struct packed {
    logic [1:0] rx_code;
    logic [1:0] tx_code;
  } lvl_cfg_t;

  function automatic logic [FIELD_W-1:0] rx_level(input logic [1:0] code);
    case (code)
      2'd0:    return FIELD_W'(1);
      2'd1:    return FIELD_W'(2);
      2'd2:    return FIELD_W'(4);
      default: return FIELD_W'(6);
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] tx_level(input logic [1:0] code);
    case (code)
      2'd0:    return FIELD_W'(0);
      2'd1:    return FIELD_W'(2);
      2'd2:    return FIELD_W'(4);
      default: return FIELD_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DW = 8,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] dout_q;
  logic          ovf_q;
  logic          empty, full, push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign push_ok = push_i & ~full & ~flush_i;
  assign pop_ok  = pop_i & ~empty & ~flush_i;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      dout_q   <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (flush_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
        cnt_q    <= '0;
      end else begin
        if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
        if (pop_ok) begin
          rd_ptr_q <= ptr_next(rd_ptr_q);
          dout_q   <= mem_q[rd_ptr_q];
        end
        if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
        else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      end
      if (push_i && full && !flush_i) ovf_q <= 1'b1;
    end
  end

  // storage needs no reset
  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= din_i;
  end

  assign dout_o = dout_q;
  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= FULL_CNT); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && push_i && !pop_i && !flush_i |=> cnt_o == FULL_CNT && ovf_o); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R8
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty && pop_i && !push_i && !flush_i |=> cnt_o == '0 && $stable(dout_o)); // R9
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty && !full && push_i && pop_i && !flush_i |=> $stable(cnt_o)); // R10
  AST_FLUSH_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_o == '0 && $stable(dout_o)); // R11
endmodule

// File: rtl/fifo_ctrl_reg.sv
module fifo_ctrl_reg
  import uart_fifo_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  logic [7:0] wdata_i,
  output lvl_cfg_t cfg_o,
  output logic     rx_flush_o,
  output logic     tx_flush_o
);
  lvl_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (wr_i) begin
      cfg_q.rx_code <= wdata_i[RX_CODE_LSB +: 2];
      cfg_q.tx_code <= wdata_i[TX_CODE_LSB +: 2];
    end
  end

  // flush strobes act at the write edge and never latch
  assign rx_flush_o = wr_i & wdata_i[RX_FLUSH_BIT];
  assign tx_flush_o = wr_i & wdata_i[TX_FLUSH_BIT];
  assign cfg_o      = cfg_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[3:2];

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cfg_o)); // R12
  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cfg_o.rx_code == $past(wdata_i[7:6]) && cfg_o.tx_code == $past(wdata_i[5:4])); // R2
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        tx_push_i,
  input  logic [7:0]  tx_din_i,
  input  logic        tx_pop_i,
  output logic [7:0]  tx_dout_o,
  output logic        tx_ovf_o,
  output logic        tx_trig_o,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_din_i,
  input  logic        rx_pop_i,
  output logic [7:0]  rx_dout_o,
  output logic        rx_ovf_o,
  output logic        rx_trig_o
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  lvl_cfg_t      cfg;
  logic          rx_flush, tx_flush;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [FIELD_W-1:0] rx_cnt_f, tx_cnt_f;

  fifo_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i[7:0]),
    .cfg_o     (cfg),
    .rx_flush_o(rx_flush),
    .tx_flush_o(tx_flush)
  );

  byte_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(tx_flush),
    .push_i (tx_push_i),
    .din_i  (tx_din_i),
    .pop_i  (tx_pop_i),
    .dout_o (tx_dout_o),
    .cnt_o  (tx_cnt),
    .ovf_o  (tx_ovf_o)
  );

  byte_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(rx_flush),
    .push_i (rx_push_i),
    .din_i  (rx_din_i),
    .pop_i  (rx_pop_i),
    .dout_o (rx_dout_o),
    .cnt_o  (rx_cnt),
    .ovf_o  (rx_ovf_o)
  );

  assign rx_cnt_f = FIELD_W'(rx_cnt);
  assign tx_cnt_f = FIELD_W'(tx_cnt);

  assign rx_trig_o = (rx_cnt_f >= rx_level(cfg.rx_code));
  assign tx_trig_o = (tx_cnt_f <= tx_level(cfg.tx_code));

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[RX_CNT_LSB +: FIELD_W] = rx_cnt_f;
    reg_rdata_o[TX_CNT_LSB +: FIELD_W] = tx_cnt_f;
    reg_rdata_o[RX_CODE_LSB +: 2]      = cfg.rx_code;
    reg_rdata_o[TX_CODE_LSB +: 2]      = cfg.tx_code;
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[31:8];

  AST_TX_TRIG_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_f == '0 |-> tx_trig_o); // R3
  AST_RX_TRIG_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_f == '0 |-> !rx_trig_o); // R2
  AST_RX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_wdata_i[1] |=> reg_rdata_o[27:24] == 4'd0); // R4
  AST_TX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_wdata_i[0] |=> reg_rdata_o[19:16] == 4'd0); // R5
endmodule

// File: tb/uart_fifo_pair_bench.sv
module uart_fifo_pair_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0]  tx_din = '0, rx_din = '0;
  logic [7:0]  tx_dout, rx_dout;
  logic        tx_ovf, rx_ovf, tx_trig, rx_trig;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] tx_last = '0, rx_last = '0;
  bit         tx_ovf_m = 0, rx_ovf_m = 0;
  logic [1:0] rx_code_m = '0, tx_code_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_pair u_uart_fifo_pair (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .tx_push_i(tx_push), .tx_din_i(tx_din), .tx_pop_i(tx_pop), .tx_dout_o(tx_dout),
    .tx_ovf_o(tx_ovf), .tx_trig_o(tx_trig),
    .rx_push_i(rx_push), .rx_din_i(rx_din), .rx_pop_i(rx_pop), .rx_dout_o(rx_dout),
    .rx_ovf_o(rx_ovf), .rx_trig_o(rx_trig)
  );

  function automatic int rx_thr(input logic [1:0] c);
    case (c) 2'd0: return 1; 2'd1: return 2; 2'd2: return 4; default: return 6; endcase
  endfunction

  function automatic int tx_thr(input logic [1:0] c);
    case (c) 2'd0: return 0; 2'd1: return 2; 2'd2: return 4; default: return 6; endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] exp_rd;
    exp_rd = '0;
    exp_rd[27:24] = 4'(rxq.size());
    exp_rd[19:16] = 4'(txq.size());
    exp_rd[7:6]   = rx_code_m;
    exp_rd[5:4]   = tx_code_m;
    chk({tag, " rdata R1 R4 R5 R12"}, reg_rdata, exp_rd);
    chk({tag, " rx_trig R2"}, 32'(rx_trig), 32'(rxq.size() >= rx_thr(rx_code_m)));
    chk({tag, " tx_trig R3"}, 32'(tx_trig), 32'(txq.size() <= tx_thr(tx_code_m)));
    chk({tag, " tx_dout R7 R9"}, 32'(tx_dout), 32'(tx_last));
    chk({tag, " rx_dout R7 R9"}, 32'(rx_dout), 32'(rx_last));
    chk({tag, " tx_ovf R8"}, 32'(tx_ovf), 32'(tx_ovf_m));
    chk({tag, " rx_ovf R8"}, 32'(rx_ovf), 32'(rx_ovf_m));
  endtask

  task automatic model_edge();
    int  n;
    bit  pok, uok;
    if (reg_wr && reg_wdata[0]) txq.delete();
    else begin
      n = txq.size(); pok = tx_pop && n > 0; uok = tx_push && n < 8;
      if (tx_push && n == 8) tx_ovf_m = 1;
      if (pok) tx_last = txq.pop_front();
      if (uok) txq.push_back(tx_din);
    end
    if (reg_wr && reg_wdata[1]) rxq.delete();
    else begin
      n = rxq.size(); pok = rx_pop && n > 0; uok = rx_push && n < 8;
      if (rx_push && n == 8) rx_ovf_m = 1;
      if (pok) rx_last = rxq.pop_front();
      if (uok) rxq.push_back(rx_din);
    end
    if (reg_wr) begin
      rx_code_m = reg_wdata[7:6];
      tx_code_m = reg_wdata[5:4];
    end
  endtask

  // inputs are set at the falling edge, results compared at the next one
  task automatic cyc(input string tag, input bit wr, input logic [31:0] wd,
                     input bit tpu, input logic [7:0] td, input bit tpo,
                     input bit rpu, input logic [7:0] rd, input bit rpo);
    reg_wr = wr; reg_wdata = wd;
    tx_push = tpu; tx_din = td; tx_pop = tpo;
    rx_push = rpu; rx_din = rd; rx_pop = rpo;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 32'hFFFF_FFFF, 0, 8'h00, 0, 0, 8'h00, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 rdata", reg_rdata, 32'h0);
    chk("R6 rx_trig", 32'(rx_trig), 32'h0);
    chk("R6 tx_trig", 32'(tx_trig), 32'h1);
    chk("R6 ovf", {30'h0, tx_ovf, rx_ovf}, 32'h0);
    chk("R6 dout", {16'h0, tx_dout, rx_dout}, 32'h0);
    rst_n = 1'b1;
    idle("R6");

    // R2 each receive code: fill to 8 then drain
    for (int c = 0; c < 4; c++) begin
      cyc("R2", 1, 32'(c) << 6, 0, 8'h00, 0, 0, 8'h00, 0);
      for (int i = 0; i < 8; i++) cyc("R2 R7", 0, 0, 0, 8'h00, 0, 1, 8'(8'h30 + i + c), 0);
      for (int i = 0; i < 8; i++) cyc("R2 R7", 0, 0, 0, 8'h00, 0, 0, 8'h00, 1);
    end

    // R3 each transmit code: push past full, pop past empty
    for (int c = 0; c < 4; c++) begin
      cyc("R3", 1, 32'(c) << 4, 0, 8'h00, 0, 0, 8'h00, 0);
      for (int i = 0; i < 9; i++) cyc("R3 R8", 0, 0, 1, 8'(8'hA0 + i + c), 0, 0, 8'h00, 0);
      for (int i = 0; i < 10; i++) cyc("R3 R7 R9", 0, 0, 0, 8'h00, 1, 0, 8'h00, 0);
    end

    // R10 simultaneous push and pop
    for (int i = 0; i < 3; i++) cyc("R10", 0, 0, 0, 8'h00, 0, 1, 8'(8'h50 + i), 0);
    for (int i = 0; i < 5; i++) cyc("R10 mid", 0, 0, 0, 8'h00, 0, 1, 8'(8'h60 + i), 1);
    cyc("R10", 1, 32'h2, 0, 8'h00, 0, 0, 8'h00, 0);
    cyc("R10 empty", 0, 0, 0, 8'h00, 0, 1, 8'h77, 1);
    for (int i = 0; i < 8; i++) cyc("R10", 0, 0, 1, 8'(8'hC0 + i), 0, 0, 8'h00, 0);
    cyc("R10 R8 full", 0, 0, 1, 8'hEE, 1, 0, 8'h00, 0);

    // R11 flush beats push and pop
    cyc("R11 R5", 1, 32'h1, 1, 8'h99, 1, 0, 8'h00, 0);
    for (int i = 0; i < 4; i++) cyc("R11", 0, 0, 0, 8'h00, 0, 1, 8'(8'h10 + i), 0);
    cyc("R11 R4", 1, 32'h2, 0, 8'h00, 0, 1, 8'h88, 1);
    for (int i = 0; i < 3; i++) cyc("R11 R7", 0, 0, 1, 8'(8'h20 + i), 0, 1, 8'(8'h40 + i), 0);
    cyc("R11 R7", 0, 0, 0, 8'h00, 1, 0, 8'h00, 1);

    // R12 reserved bits and write strobe
    cyc("R12", 1, 32'hFFFF_FF8C, 0, 8'h00, 0, 0, 8'h00, 0);
    idle("R12 no write");
    cyc("R12", 1, 32'hF0F0_F0F0, 0, 8'h00, 0, 0, 8'h00, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom();
      cyc("RND R1 R7", (r[3:0] == 4'h0), $urandom(), r[4], 8'(r[15:8]), r[5] & r[6],
          r[7], 8'(r[23:16]), r[24] & r[25]);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule